// File: doc/BRIEF.md
# Cascadable Dual Pulse Generator

This block holds two 8-bit down-counting pulse channels that share one prescaled count clock. Each channel alternates between a low phase and a high phase; on every underflow it reloads the length of the coming phase and flips its pulse pin. The pair runs in one of three arrangements. The channels can be two independent generators. Channel 0 can act as a prescaler that steps channel 1 once per underflow. Or the two can be joined into one 16-bit generator, with channel 1 as the upper byte.

A narrow write port loads one 8-bit control register and four reload registers. The control register holds an interrupt enable, an underflow flag, a spare interrupt-mode bit, the count-clock divider and the arrangement. The flag records underflows: those of channel 0 in the 8-bit arrangements, and those of the joined counter in the 16-bit one. Software clears it by writing 0. The interrupt request follows the flag, gated by the enable. The register contents are always visible on `ctrl_o`.

Top module: `dual_ppg`

## Requirements
- R1: While reset is low, `ctrl_o` bits 7..1 are 0, both pulse pins are low and `irq_o` is low.
- R2: A write to address 0 stores bit 7 as interrupt enable, bit 5 as interrupt mode, bits 4:3 as divider select and bits 2:1 as arrangement. These fields read back at the same positions on `ctrl_o`. Bit 0 has no effect on behaviour.
- R3: In arrangement 00, each channel drives its pin high for (high reload + 1) count ticks and low for (low reload + 1) count ticks. Reloads are at address 1 (ch0 low), 2 (ch0 high), 3 (ch1 low) and 4 (ch1 high).
- R4: Divider select 00, 01, 10 and 11 gives one count tick every 1, 4, 16 and 64 clock cycles.
- R5: In arrangement 01, channel 1 counts one step for each channel 0 underflow.
- R6: In arrangement 11, the pair counts as one 16-bit value {ch1, ch0}. It reloads from {ch1 reload, ch0 reload} only when the whole value wraps, so a high phase lasts ({hi1,hi0} + 1) ticks. Both pins carry the joined level, and only the joined wrap sets the flag.
- R7: Arrangement 10 behaves exactly like arrangement 00.
- R8: In arrangements 00 and 01, the flag (bit 6) is set by channel 0 underflows only.
- R9: Writing 0 to bit 6 clears the flag. Writing 1 to bit 6 leaves it unchanged.
- R10: If an underflow and a clearing write land on the same clock edge, the flag ends up set.
- R11: `irq_o` is high exactly when the enable and the flag are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe, one register per cycle |
| wr_addr_i | input | 3 | 0 control, 1..4 reload registers |
| wr_data_i | input | 8 | Write data |
| ctrl_o | output | 8 | Current control register contents |
| pulse_o | output | 2 | Pulse pins, index = channel |
| irq_o | output | 1 | Interrupt request |

## Verification
The flag can be set by a counter underflow and cleared by a register write on the same clock edge. The bench runs channel 0 with a known ten-tick phase and places the clearing write so that it takes effect on the very edge where the pulse pin falls. It then checks that the pin has changed and that the flag still reads 1. A separate write placed well clear of any underflow confirms that the same clear does work on its own.

// File: rtl/dppg_pkg.sv
package dppg_pkg;
  typedef enum logic [1:0] {
    MD_DUAL  = 2'b00,
    MD_PRESC = 2'b01,
    MD_RSVD  = 2'b10,
    MD_JOIN  = 2'b11
  } mode_e;

  typedef struct packed {
    logic       ie;
    logic       uf;
    logic       imode;
    logic [1:0] pcs;
    logic [1:0] md;
    logic       spare;
  } ctrl_t;

  localparam logic [2:0] ADDR_CTRL = 3'd0;
  localparam int         NCH       = 2;
  localparam int         NPH       = 2;
endpackage

// File: rtl/dppg_prescale.sv
module dppg_prescale #(
  parameter int STEP = 2,
  parameter int NSEL = 4,
  localparam int SW   = $clog2(NSEL),
  localparam int CNTW = STEP * (NSEL - 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [SW-1:0] sel_i,
  output logic          tick_o
);
  logic [CNTW-1:0] cnt_q;
  logic [NSEL-1:0] tick_v;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  for (genvar g = 0; g < NSEL; g++) begin : g_tap
    localparam int LW = STEP * g;
    if (LW == 0) begin : g_full
      assign tick_v[g] = 1'b1;
    end else begin : g_div
      assign tick_v[g] = &cnt_q[LW-1:0];
    end
  end

  assign tick_o = tick_v[sel_i];

  p_div4_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && sel_i == SW'(1) && $stable(sel_i)) |=> (!tick_o || sel_i != SW'(1)));
endmodule

// File: rtl/dppg_chan.sv
module dppg_chan #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         hold_i,
  input  logic         load_i,
  input  logic         load_hi_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  output logic [W-1:0] cnt_o,
  output logic         zero_o,
  output logic         uf_o,
  output logic         level_o
);
  logic [W-1:0] cnt_q;
  logic         lvl_q;

  assign zero_o  = (cnt_q == '0);
  assign uf_o    = tick_i & zero_o & ~hold_i & ~load_i;
  assign cnt_o   = cnt_q;
  assign level_o = lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= load_hi_i ? hi_i : lo_i;
      lvl_q <= load_hi_i;
    end else if (uf_o) begin
      cnt_q <= lvl_q ? lo_i : hi_i;
      lvl_q <= ~lvl_q;
    end else if (tick_i) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  p_toggle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf_o |=> (level_o != $past(level_o)));

  p_wrap_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && hold_i && zero_o && !load_i) |=> (cnt_o == '1 && $stable(level_o)));
endmodule

// File: rtl/dppg_ctrl.sv
module dppg_ctrl
  import dppg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  input  logic       set_i,
  output ctrl_t      ctrl_o,
  output logic       irq_o
);
  ctrl_t wr_w;
  logic  ie_q, uf_q, im_q, sp_q;
  logic [1:0] pcs_q, md_q;

  assign wr_w = ctrl_t'(wdata_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q  <= 1'b0;
      im_q  <= 1'b0;
      pcs_q <= '0;
      md_q  <= '0;
      sp_q  <= 1'b0;
    end else if (we_i) begin
      ie_q  <= wr_w.ie;
      im_q  <= wr_w.imode;
      pcs_q <= wr_w.pcs;
      md_q  <= wr_w.md;
      sp_q  <= wr_w.spare;
    end
  end

  // event beats software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                uf_q <= 1'b0;
    else if (set_i)             uf_q <= 1'b1;
    else if (we_i && !wr_w.uf)  uf_q <= 1'b0;
  end

  always_comb begin
    ctrl_o.ie    = ie_q;
    ctrl_o.uf    = uf_q;
    ctrl_o.imode = im_q;
    ctrl_o.pcs   = pcs_q;
    ctrl_o.md    = md_q;
    ctrl_o.spare = sp_q;
  end

  assign irq_o = ie_q & uf_q;

  p_set_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> ctrl_o.uf);

  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !wdata_i[6] && !set_i) |=> !ctrl_o.uf);

  p_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wdata_i[6] && !set_i) |=> (ctrl_o.uf == $past(ctrl_o.uf)));
endmodule

// File: rtl/dual_ppg.sv
module dual_ppg
  import dppg_pkg::*;
#(
  parameter int W    = 8,
  parameter int STEP = 2,
  parameter int NSEL = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [2:0]   wr_addr_i,
  input  logic [W-1:0] wr_data_i,
  output logic [7:0]   ctrl_o,
  output logic [1:0]   pulse_o,
  output logic         irq_o
);
  localparam int SW = $clog2(NSEL);

  ctrl_t ctrl_w;
  mode_e mode_w;
  logic  tick_w, join_w, presc_w, uf16_w;
  logic  [NCH-1:0] zero_w, uf_w, lvl_w, tick_ch_w;
  logic  [NCH-1:0][W-1:0] cnt_w;
  logic  [NCH-1:0][NPH-1:0][W-1:0] rel_q;

  // reload bank: address 1 + 2*channel + phase (phase 0 low, 1 high)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rel_q <= '0;
    end else if (wr_en_i) begin
      for (int c = 0; c < NCH; c++) begin
        for (int p = 0; p < NPH; p++) begin
          if (wr_addr_i == 3'(1 + NPH * c + p)) rel_q[c][p] <= wr_data_i;
        end
      end
    end
  end

  dppg_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en_i && wr_addr_i == ADDR_CTRL),
    .wdata_i (wr_data_i[7:0]),
    .set_i   (uf16_w | uf_w[0]),
    .ctrl_o  (ctrl_w),
    .irq_o   (irq_o)
  );

  dppg_prescale #(.STEP(STEP), .NSEL(NSEL)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (SW'(ctrl_w.pcs)),
    .tick_o (tick_w)
  );

  assign mode_w  = mode_e'(ctrl_w.md);
  assign join_w  = (mode_w == MD_JOIN);
  assign presc_w = (mode_w == MD_PRESC);
  assign uf16_w  = join_w & tick_w & zero_w[0] & zero_w[1];

  always_comb begin
    tick_ch_w[0] = tick_w;
    if (join_w)       tick_ch_w[1] = tick_w & zero_w[0];
    else if (presc_w) tick_ch_w[1] = uf_w[0];
    else              tick_ch_w[1] = tick_w;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dppg_chan #(.W(W)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick_ch_w[c]),
      .hold_i    (join_w),
      .load_i    (uf16_w),
      .load_hi_i (~lvl_w[0]),
      .lo_i      (rel_q[c][0]),
      .hi_i      (rel_q[c][1]),
      .cnt_o     (cnt_w[c]),
      .zero_o    (zero_w[c]),
      .uf_o      (uf_w[c]),
      .level_o   (lvl_w[c])
    );
  end

  assign ctrl_o  = ctrl_w;
  assign pulse_o = join_w ? {lvl_w[0], lvl_w[0]} : lvl_w;

  p_join_sync_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf16_w |=> (lvl_w[1] == lvl_w[0]));

  p_join_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf16_w |=> ({cnt_w[1], cnt_w[0]} == ($past(lvl_w[0])
      ? {$past(rel_q[1][0]), $past(rel_q[0][0])}
      : {$past(rel_q[1][1]), $past(rel_q[0][1])})));
endmodule

// File: tb/dual_ppg_bench.sv
module dual_ppg_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] ctrl;
  logic [1:0] pulse;
  logic       irq;
  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  dual_ppg u_dual_ppg (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .ctrl_o(ctrl), .pulse_o(pulse), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // call at a negedge; write lands on the next posedge
  task automatic wr_now(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_now(a, d);
  endtask

  task automatic meas(input int idx, input logic v, output int n);
    n = 0;
    while (pulse[idx] == v) @(negedge clk);
    while (pulse[idx] != v) @(negedge clk);
    while (pulse[idx] == v) begin n++; @(negedge clk); end
  endtask

  task automatic wait_rise0();
    while (pulse[0] == 1'b1) @(negedge clk);
    while (pulse[0] == 1'b0) @(negedge clk);
  endtask

  task automatic t_reset();
    chk((ctrl & 8'hFE) == 8'h00, "R1 ctrl", ctrl, 0);
    chk(pulse == 2'b00, "R1 pulse", pulse, 0);
    chk(irq == 1'b0, "R1 irq", irq, 0);
  endtask

  task automatic t_fields();
    wr(0, 8'hA5);
    chk((ctrl & 8'hBE) == 8'hA4, "R2 fields", ctrl & 8'hBE, 8'hA4);
    wr(0, 8'h1A);
    chk((ctrl & 8'hBE) == 8'h1A, "R2 fields2", ctrl & 8'hBE, 8'h1A);
    wr(0, 8'h00);
  endtask

  task automatic t_dual();
    int n;
    wr(1, 2); wr(2, 3); wr(3, 5); wr(4, 1);
    wr(0, 8'h00);
    meas(0, 1, n); meas(0, 1, n);
    chk(n == 4, "R3 ch0 high", n, 4);
    meas(0, 0, n);
    chk(n == 3, "R3 ch0 low", n, 3);
    meas(1, 1, n); meas(1, 1, n);
    chk(n == 2, "R3 ch1 high", n, 2);
    meas(1, 0, n);
    chk(n == 6, "R3 ch1 low", n, 6);
  endtask

  task automatic t_rsvd();
    int n;
    wr(0, 8'h04);
    meas(1, 1, n); meas(1, 1, n);
    chk(n == 2, "R7 ch1 high", n, 2);
    meas(1, 0, n);
    chk(n == 6, "R7 ch1 low", n, 6);
    meas(0, 1, n);
    chk(n == 4, "R7 ch0 high", n, 4);
  endtask

  task automatic t_prescale();
    int n;
    wr(1, 3); wr(2, 3);
    for (int s = 0; s < 4; s++) begin
      wr(0, 8'(s << 3));
      meas(0, 1, n); meas(0, 1, n);
      chk(n == 4 * (1 << (2 * s)), "R4 divider", n, 4 * (1 << (2 * s)));
    end
    wr(0, 8'h00);
  endtask

  task automatic t_cascade();
    int n;
    wr(1, 1); wr(2, 1); wr(3, 0); wr(4, 2);
    wr(0, 8'h02);
    meas(1, 1, n); meas(1, 1, n);
    chk(n == 6, "R5 ch1 high", n, 6);
    meas(1, 0, n);
    chk(n == 2, "R5 ch1 low", n, 2);
  endtask

  task automatic t_join();
    int n;
    int bad_f = 0;
    int bad_p = 0;
    wr(1, 5); wr(2, 2); wr(3, 0); wr(4, 1);
    wr(0, 8'h06);
    meas(0, 1, n); meas(0, 1, n);
    chk(n == 259, "R6 joined high", n, 259);
    meas(0, 0, n);
    chk(n == 6, "R6 joined low", n, 6);
    wait_rise0();
    wr_now(0, 8'h06);
    chk(ctrl[6] == 1'b0, "R6 flag cleared", ctrl[6], 0);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (ctrl[6]) bad_f++;
      if (pulse[1] != pulse[0]) bad_p++;
    end
    chk(bad_f == 0, "R6 no flag on byte wrap", bad_f, 0);
    chk(bad_p == 0, "R6 pins equal", bad_p, 0);
    while (pulse[0] == 1'b1) @(negedge clk);
    chk(ctrl[6] == 1'b1, "R6 flag on joined wrap", ctrl[6], 1);
  endtask

  task automatic t_flag_src();
    int bad = 0;
    wr(1, 200); wr(2, 200); wr(3, 0); wr(4, 0);
    wr(0, 8'h00);
    wait_rise0(); wait_rise0();
    wr_now(0, 8'h00);
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      if (ctrl[6]) bad++;
    end
    chk(bad == 0, "R8 ch1 underflow ignored", bad, 0);
    while (pulse[0] == 1'b1) @(negedge clk);
    chk(ctrl[6] == 1'b1, "R8 ch0 underflow sets", ctrl[6], 1);
  endtask

  task automatic t_flag_wr();
    wr(0, 8'h40);
    chk(ctrl[6] == 1'b1, "R9 write 1 keeps", ctrl[6], 1);
    wr(0, 8'h00);
    chk(ctrl[6] == 1'b0, "R9 write 0 clears", ctrl[6], 0);
  endtask

  task automatic t_collide();
    int n;
    wr(1, 9); wr(2, 9);
    meas(0, 1, n); meas(0, 1, n);
    chk(n == 10, "R10 phase length", n, 10);
    wait_rise0();
    wr_now(0, 8'h00);
    chk(ctrl[6] == 1'b0, "R10 plain clear", ctrl[6], 0);
    repeat (8) @(negedge clk);
    wr_now(0, 8'h00);
    chk(pulse[0] == 1'b0, "R10 underflow on same edge", pulse[0], 0);
    chk(ctrl[6] == 1'b1, "R10 set wins", ctrl[6], 1);
  endtask

  task automatic t_irq();
    wr(0, 8'hC0);
    chk(irq == 1'b1, "R11 enabled flag", irq, 1);
    wr(0, 8'h40);
    chk(irq == 1'b0 && ctrl[6], "R11 disabled", irq, 0);
    wr(1, 200); wr(2, 200);
    wait_rise0(); wait_rise0();
    wr_now(0, 8'h80);
    chk(irq == 1'b0, "R11 flag clear", irq, 0);
    while (pulse[0] == 1'b1) @(negedge clk);
    chk(irq == 1'b1, "R11 underflow raises", irq, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_fields();
    t_dual();
    t_rsvd();
    t_prescale();
    t_cascade();
    t_join();
    t_flag_src();
    t_flag_wr();
    t_collide();
    t_irq();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule